// File: doc/BRIEF.md
# Presettable Up/Down Counter with Clocked Carry

This block is a 4-bit synchronous binary counter whose direction is set by a single input. Its state can be cleared in two ways, either at once or on the next clock edge, and it can be preset from a 4-bit data word on the next clock edge. It advances only when two separate active-low count enables are both asserted. The two enables are a parallel enable and a trickle enable. The trickle enable also qualifies the terminal-count flag. The state is presented on a three-state data bus. Disabling that bus does not stop the counter internally.

Two cascade outputs are provided. The terminal-count flag is combinational, and it marks the last state in the current direction. The clocked carry is a pulse that can only be low while the clock is low. It is safe to use as a clock or reset for downstream logic. The block has no streaming data path, so no valid/ready handshake applies. Every pin is a plain level-sensitive control or status signal.

Top module: `updn_preset_counter`

## Requirements
- R1: With `up_dn` high (1 = up), counting increments the state by one on each rising edge, and 15 wraps to 0.
- R2: With `up_dn` low (0 = down), counting decrements the state by one on each rising edge, and 0 wraps to 15.
- R3: While `arst_n` is low, the state is 0 at once, with no clock edge required, and all other inputs are overridden.
- R4: `sclr_n` low clears the state to 0 on the next rising edge, taking priority over load and count.
- R5: `load_n` low (with `sclr_n` high) copies `preset` into the state on the next rising edge, taking priority over counting.
- R6: With both clears and the load inactive, the state changes only when both `en_par_n` and `en_trk_n` are low. A high level on either one holds the state.
- R7: `tc_n` is low exactly when `en_trk_n` is low and the state is 15 in up mode or 0 in down mode. It reacts to `up_dn` and `en_trk_n` without waiting for a clock edge.
- R8: `cc_n` is low only while `clk` is low and, at the same time, `tc_n`, `en_par_n` and `en_trk_n` are low with `arst_n`, `sclr_n` and `load_n` high. It is high whenever `clk` is high.
- R9: `out_en_n` high puts `data_q` into high impedance, and counting, loading and clearing carry on internally. `out_en_n` low drives the state onto `data_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| arst_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous preset load, active low |
| en_par_n | input | 1 | Parallel count enable, active low |
| en_trk_n | input | 1 | Trickle count enable, active low; also gates `tc_n` |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| preset | input | 4 | Value loaded when `load_n` is low |
| out_en_n | input | 1 | Output enable for `data_q`, active low |
| data_q | output | 4 | Three-state counter state |
| tc_n | output | 1 | Terminal-count flag, active low, combinational |
| cc_n | output | 1 | Clock-phase-gated carry, active low |

## Verification
Clearing, loading and counting can all be requested at the same clock edge. The bench provokes this by asserting a load, both enables and then the synchronous clear together. It expects the clear to win, and without the clear it expects the preset value, never the counted value. The terminal-count and clocked-carry logic both act in the cycle that wraps the state. The bench samples `cc_n` in the high phase and in the low phase before that edge, and then checks that both cascade outputs release once the wrap has taken place.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } ctr_mode_e;

endpackage

// File: rtl/updn_ctr_mode_sel.sv
// Resolves the synchronous controls into one operating mode.
// Priority: clear, then load, then count, then hold.
module updn_ctr_mode_sel
  import updn_ctr_pkg::*;
(
  input  logic      sclr_n,
  input  logic      load_n,
  input  logic      en_par_n,
  input  logic      en_trk_n,
  output ctr_mode_e mode
);

  always_comb begin
    if (!sclr_n)                      mode = MODE_CLEAR;
    else if (!load_n)                 mode = MODE_LOAD;
    else if (!en_par_n && !en_trk_n)  mode = MODE_COUNT;
    else                              mode = MODE_HOLD;
  end

endmodule

// File: rtl/updn_ctr_next.sv
// Next-state computation; wrap-around comes from modulo-2^W arithmetic.
module updn_ctr_next
  import updn_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] preset,
  input  logic         up_dn,
  input  ctr_mode_e    mode,
  output logic [W-1:0] state_nxt
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] stepped;

  assign stepped = up_dn ? state + ONE : state - ONE;

  always_comb begin
    unique case (mode)
      MODE_CLEAR: state_nxt = '0;
      MODE_LOAD:  state_nxt = preset;
      MODE_COUNT: state_nxt = stepped;
      default:    state_nxt = state;
    endcase
  end

endmodule

// File: rtl/updn_ctr_carry.sv
// Terminal-count decode and clock-phase-gated carry.
module updn_ctr_carry #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         sclr_n,
  input  logic         load_n,
  input  logic         en_par_n,
  input  logic         en_trk_n,
  input  logic         up_dn,
  input  logic [W-1:0] state,
  output logic         tc_n,
  output logic         cc_n
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic at_end;
  logic carry_armed;

  assign at_end      = up_dn ? (state == TOP) : (state == '0);
  assign tc_n        = ~(at_end & ~en_trk_n);
  assign carry_armed = arst_n & sclr_n & load_n & ~en_par_n & ~en_trk_n & ~tc_n;
  // Low only in the low clock phase; released as soon as the clock rises.
  assign cc_n        = ~(carry_armed & ~clk);

  // R7: the terminal flag is never active while the trickle enable is off
  assert_tc_needs_trickle_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !tc_n |-> !en_trk_n);

  // R8: sampled just before the rising edge (clock still low), a low carry
  // implies terminal count, parallel enable and no pending clear or load
  assert_cc_qualified_R8: assert property (@(posedge clk) disable iff (!arst_n)
    !cc_n |-> (!tc_n && !en_par_n && sclr_n && load_n));

endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
  import updn_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         sclr_n,
  input  logic         load_n,
  input  logic         en_par_n,
  input  logic         en_trk_n,
  input  logic         up_dn,
  input  logic [W-1:0] preset,
  input  logic         out_en_n,
  output wire  [W-1:0] data_q,
  output logic         tc_n,
  output logic         cc_n
);

  ctr_mode_e    mode;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  updn_ctr_mode_sel u_mode (
    .sclr_n   (sclr_n),
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .mode     (mode)
  );

  updn_ctr_next #(.W(W)) u_next (
    .state     (cnt_q),
    .preset    (preset),
    .up_dn     (up_dn),
    .mode      (mode),
    .state_nxt (cnt_nxt)
  );

  updn_ctr_carry #(.W(W)) u_carry (
    .clk      (clk),
    .arst_n   (arst_n),
    .sclr_n   (sclr_n),
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .up_dn    (up_dn),
    .state    (cnt_q),
    .tc_n     (tc_n),
    .cc_n     (cc_n)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end

  assign data_q = out_en_n ? {W{1'bz}} : cnt_q;

  assert_sync_clear_R4: assert property (@(posedge clk) disable iff (!arst_n)
    !sclr_n |=> (cnt_q == '0));

  assert_load_preset_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (sclr_n && !load_n) |=> (cnt_q == $past(preset)));

  assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (sclr_n && load_n && (en_par_n || en_trk_n)) |=> $stable(cnt_q));

  assert_up_wrap_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (sclr_n && load_n && !en_par_n && !en_trk_n && up_dn && cnt_q == {W{1'b1}})
    |=> (cnt_q == '0));

  assert_down_wrap_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (sclr_n && load_n && !en_par_n && !en_trk_n && !up_dn && cnt_q == '0)
    |=> (cnt_q == {W{1'b1}}));

endmodule

// File: tb/test_updn_preset_counter.sv
module test_updn_preset_counter;

  logic       clk = 1'b0;
  logic       arst_n, sclr_n, load_n, en_par_n, en_trk_n, up_dn, out_en_n;
  logic [3:0] preset;
  wire  [3:0] q_bus;
  logic       tc_n, cc_n;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;  // 100 MHz

  // Weak pull-ups show a released bus as all ones at the ports
  for (genvar b = 0; b < 4; b++) begin : g_pu
    pullup (q_bus[b]);
  end

  updn_preset_counter i_updn_preset_counter (
    .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n),
    .en_par_n(en_par_n), .en_trk_n(en_trk_n), .up_dn(up_dn),
    .preset(preset), .out_en_n(out_en_n), .data_q(q_bus),
    .tc_n(tc_n), .cc_n(cc_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Moves to 2 ns after the next rising edge (clock high)
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    sclr_n = 1; load_n = 1; en_par_n = 1; en_trk_n = 1;
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_n = 0;
    tick();
    load_n = 1;
  endtask

  task automatic t_reset();
    chk("R3", "state in reset", q_bus, 4'h0);
    arst_n = 1;
    do_load(4'hA);
    chk("R5", "preset before async clear", q_bus, 4'hA);
    #1 arst_n = 0;
    #1 chk("R3", "async clear between edges", q_bus, 4'h0);
    en_par_n = 0; en_trk_n = 0;
    tick();
    chk("R3", "clear overrides counting", q_bus, 4'h0);
    arst_n = 1; idle();
  endtask

  task automatic t_up();
    up_dn = 1;
    do_load(4'd13);
    chk("R5", "load 13", q_bus, 4'd13);
    en_par_n = 0; en_trk_n = 0;
    tick(); chk("R1", "up 14", q_bus, 4'd14);
    tick(); chk("R1", "up 15", q_bus, 4'd15);
    tick(); chk("R1", "wrap 15->0", q_bus, 4'd0);
    tick(); chk("R1", "up 1", q_bus, 4'd1);
    idle();
  endtask

  task automatic t_down();
    up_dn = 0;
    en_par_n = 0; en_trk_n = 0;
    preset = 4'd2; load_n = 0;
    tick(); chk("R5", "load beats count", q_bus, 4'd2);
    load_n = 1;
    tick(); chk("R2", "down 1", q_bus, 4'd1);
    tick(); chk("R2", "down 0", q_bus, 4'd0);
    tick(); chk("R2", "wrap 0->15", q_bus, 4'd15);
    tick(); chk("R2", "down 14", q_bus, 4'd14);
    idle(); up_dn = 1;
  endtask

  task automatic t_sclr();
    do_load(4'd9);
    sclr_n = 0; load_n = 0; preset = 4'd7; en_par_n = 0; en_trk_n = 0;
    tick(); chk("R4", "clear beats load and count", q_bus, 4'd0);
    idle();
  endtask

  task automatic t_hold();
    up_dn = 1;
    do_load(4'd6);
    en_par_n = 1; en_trk_n = 0;
    tick(); chk("R6", "hold on parallel disable", q_bus, 4'd6);
    en_par_n = 0; en_trk_n = 1;
    tick(); chk("R6", "hold on trickle disable", q_bus, 4'd6);
    en_trk_n = 0;
    tick(); chk("R6", "count with both enables", q_bus, 4'd7);
    idle();
  endtask

  task automatic t_tc();
    up_dn = 1;
    do_load(4'd15);
    #1 chk("R7", "tc off, trickle disabled", {3'b0, tc_n}, 4'd1);
    en_trk_n = 0;
    #1 chk("R7", "tc at 15 up", {3'b0, tc_n}, 4'd0);
    up_dn = 0;
    #1 chk("R7", "tc drops on direction change", {3'b0, tc_n}, 4'd1);
    do_load(4'd0);
    #1 chk("R7", "tc at 0 down", {3'b0, tc_n}, 4'd0);
    en_trk_n = 1;
    #1 chk("R7", "tc drops on trickle change", {3'b0, tc_n}, 4'd1);
    idle(); up_dn = 1;
  endtask

  task automatic t_cc();
    up_dn = 1;
    do_load(4'd15);
    en_par_n = 0; en_trk_n = 0;
    #1 chk("R8", "carry high in high phase", {3'b0, cc_n}, 4'd1);
    #4 chk("R8", "carry low in low phase", {3'b0, cc_n}, 4'd0);
    tick(); chk("R1", "wrap after carry", q_bus, 4'd0);
    #5 chk("R8", "carry released after wrap", {3'b0, cc_n}, 4'd1);
    idle();
    do_load(4'd15);
    en_trk_n = 0;
    #5 chk("R8", "no carry, parallel disabled", {3'b0, cc_n}, 4'd1);
    chk("R7", "tc still active", {3'b0, tc_n}, 4'd0);
    tick();
    en_par_n = 0; load_n = 0; preset = 4'd15;
    #5 chk("R8", "no carry during load", {3'b0, cc_n}, 4'd1);
    idle();
  endtask

  task automatic t_oe();
    up_dn = 1;
    do_load(4'd5);
    out_en_n = 1;
    #1 chk("R9", "bus released (pulled high)", q_bus, 4'hF);
    en_par_n = 0; en_trk_n = 0;
    tick(); tick();
    chk("R9", "bus still released", q_bus, 4'hF);
    idle();
    out_en_n = 0;
    #1 chk("R9", "counted while released", q_bus, 4'd7);
  endtask

  initial begin
    arst_n = 0; idle(); up_dn = 1; out_en_n = 0; preset = 4'h0;
    tick(); tick();
    t_reset();
    t_up();
    t_down();
    t_sclr();
    t_hold();
    t_tc();
    t_cc();
    t_oe();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule